// File: doc/BRIEF.md
# DMA Global Configuration and Debug-Freeze Controller

This block holds the configuration word of a two-channel DMA engine and drives the low-power and debug-freeze controls that come from it. The word can be reached at one address per channel. The stop control and the freeze-mode field exist only once, so both addresses show the same copy of them. The remaining fields are held separately for each channel. Only supervisor accesses are accepted.

Setting the stop bit removes a glitch-free clock enable from the DMA core. The enable is updated on the falling clock edge. While the block is stopped, the configuration word can still be reached. Any other address in the DMA register window ends with a bus error.

In freeze-on-boundary mode, a debug freeze request withholds the core's bus request. The request is never cut in the middle of a DMA bus cycle. The transfer engine is represented here by a busy flag, and the end of a bus cycle is taken as the boundary.

Top module: `dma_cfg_ctl`

## Requirements
- R1: After reset, both configuration addresses (0x780 for channel 0, 0x7A0 for channel 1) read 0x0080, the core clock enable is 1, and the bus request follows the core's request.
- R2: A supervisor access to a configuration address is acknowledged one cycle later. A read returns the word with stop at bit 15, freeze mode at bits 14:13, SE at bit 12, a zero at bit 11, ISM at bits 10:8, SUPV at bit 7, the arbitration ID at 6:4 and the priority at 3:0. A write returns 0 on the data output.
- R3: The stop bit and freeze-mode bits written through either address are read back through both addresses. The other fields are kept per channel.
- R4: A user-mode access to a configuration address returns a bus error with no acknowledge and data 0, and changes no stored bit.
- R5: A written stop bit of 1 drops the core clock enable at the next falling clock edge. The configuration word stays readable and writable. Writing stop back to 0 raises the enable again.
- R6: While stop is 1, an access to any other address in 0x780–0x7BF gets a bus error. While stop is 0, such an access gets neither an acknowledge nor a bus error.
- R7: With freeze mode 10, freeze asserted and no DMA bus cycle in progress, the bus request is held low from the next cycle.
- R8: With freeze mode 10, a freeze asserted during a bus cycle does not withhold the request until the cycle ends (busy falls).
- R9: Once withheld, the bus request stays low until freeze is negated, whatever busy does. It follows the core's request again from the next cycle.
- R10: Freeze modes 00, 01 and 11 ignore the freeze input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Single-cycle access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_super | input | 1 | 1 = supervisor access |
| acc_addr | input | 12 | Register byte address |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid with acc_ack |
| acc_ack | output | 1 | Access completed normally |
| acc_berr | output | 1 | Access terminated with bus error |
| freeze_in | input | 1 | Debug freeze request |
| core_busy | input | 1 | A DMA bus cycle is in progress |
| core_req | input | 1 | Bus request from the transfer engine |
| bus_req | output | 1 | Bus request after freeze gating |
| core_clk_en | output | 1 | Clock enable for the DMA core |

## Verification
Access responses (acknowledge, bus error, read data) are registered and are due on the clock edge after the strobe cycle. The bench therefore drives the strobe 1 ns after one edge and samples 2 ns after the next. The freeze hold is also registered, so each change of freeze or busy is driven after an edge and bus_req is read 2 ns after the following edge. The clock enable changes on the falling edge after the write edge, so it is checked after the next rising edge, by which time it is settled.

// File: rtl/dma_cfg_pkg.sv
// Package: shared widths, field positions and address map of the DMA
// configuration block. Assumes a 16-bit word and byte addresses.
package dma_cfg_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 16;
    localparam int NUM_CH    = 2;
    localparam int CFG_BASE  = 12'h780;
    localparam int CH_STRIDE = 12'h020;
    localparam int WIN_SIZE  = NUM_CH * CH_STRIDE;

    // bit positions of the configuration word
    localparam int B_STOP  = 15;
    localparam int B_FRZH  = 14;
    localparam int B_FRZL  = 13;
    localparam int B_SE    = 12;
    localparam int B_SUPV  = 7;

    localparam logic [1:0] FRZ_BOUNDARY = 2'b10;

    typedef struct packed {
        logic       se;
        logic [2:0] ism;
        logic       supv;
        logic [2:0] maid;
        logic [3:0] iarb;
    } chan_cfg_t;

    localparam chan_cfg_t CHAN_RST = '{se: 1'b0, ism: 3'd0, supv: 1'b1,
                                       maid: 3'd0, iarb: 4'd0};
endpackage

// File: rtl/dma_cfg_regs.sv
// Module: configuration storage and access decode.
// Holds one shared stop/freeze copy and one field set per channel, decodes
// single-cycle accesses and returns a registered ack or bus error.
// Assumes acc_valid is a one-cycle strobe.
module dma_cfg_regs
    import dma_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_super,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_ack,
    output logic              acc_berr,
    output logic              stop,
    output logic [1:0]        frz_mode
);
    logic [NUM_CH-1:0] ch_hit;
    logic [DATA_W-1:0] ch_word [NUM_CH];
    logic              any_hit;
    logic              in_win;
    logic              good_acc;
    logic [DATA_W-1:0] sel_word;

    // window decode for the whole DMA register range
    assign in_win = (acc_addr >= ADDR_W'(CFG_BASE)) &&
                    (acc_addr <  ADDR_W'(CFG_BASE + WIN_SIZE));
    assign any_hit  = |ch_hit;
    assign good_acc = acc_valid && any_hit && acc_super;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            chan_cfg_t fld;

            assign ch_hit[g] = (acc_addr == ADDR_W'(CFG_BASE + g * CH_STRIDE));

            // per-channel field storage, written only by a good write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fld <= CHAN_RST;
                else if (good_acc && acc_write && ch_hit[g])
                    fld <= '{se: acc_wdata[B_SE], ism: acc_wdata[10:8],
                             supv: acc_wdata[B_SUPV], maid: acc_wdata[6:4],
                             iarb: acc_wdata[3:0]};
            end

            // read word assembly with shared bits and a zero at bit 11
            assign ch_word[g] = {stop, frz_mode, fld.se, 1'b0, fld.ism,
                                 fld.supv, fld.maid, fld.iarb};
        end
    endgenerate

    // shared stop and freeze-mode copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop     <= 1'b0;
            frz_mode <= 2'b00;
        end else if (good_acc && acc_write) begin
            stop     <= acc_wdata[B_STOP];
            frz_mode <= {acc_wdata[B_FRZH], acc_wdata[B_FRZL]};
        end
    end

    // read multiplexer across the channel words
    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (ch_hit[i]) sel_word = ch_word[i];
    end

    // registered bus response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_ack   <= 1'b0;
            acc_berr  <= 1'b0;
            acc_rdata <= '0;
        end else begin
            acc_ack   <= good_acc;
            acc_berr  <= acc_valid && ((any_hit && !acc_super) ||
                                       (!any_hit && in_win && stop));
            acc_rdata <= (good_acc && !acc_write) ? sel_word : '0;
        end
    end

    a_r4_user_berr: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && any_hit && !acc_super |=> acc_berr && !acc_ack);
    a_r4_user_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_super |=> $stable(stop) && $stable(frz_mode));
    a_r2_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_ack && acc_berr));
    a_r6_stopped_other: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && !any_hit && stop |=> acc_berr);
endmodule

// File: rtl/dma_cfg_freeze.sv
// Module: debug-freeze gate for the bus request.
// In boundary mode a freeze withholds the request only when no DMA bus cycle
// is in progress, and holds it until freeze drops. Assumes core_busy is high
// for the whole of each DMA bus cycle.
module dma_cfg_freeze
    import dma_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] frz_mode,
    input  logic       freeze_in,
    input  logic       core_busy,
    input  logic       core_req,
    output logic       bus_req
);
    logic held;
    logic boundary_mode;

    assign boundary_mode = (frz_mode == FRZ_BOUNDARY);

    // hold state: set at an idle boundary, kept while freeze stays high
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= 1'b0;
        else
            held <= boundary_mode && freeze_in && (held || !core_busy);
    end

    assign bus_req = core_req && !held;

    a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        held && freeze_in && boundary_mode |=> held);
    a_r8_no_cut_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !held && core_busy |=> !held);
    a_r10_other_modes: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_mode |=> !held);
endmodule

// File: rtl/dma_cfg_clkgate.sv
// Module: core clock-enable register.
// Samples the inverted stop bit on the falling edge so the enable only moves
// while the clock is low. Assumes the enable is ANDed with the clock downstream.
module dma_cfg_clkgate (
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    output logic core_clk_en
);
    // low-phase update of the enable
    always_ff @(negedge clk) begin
        if (!rst_n)
            core_clk_en <= 1'b1;
        else
            core_clk_en <= !stop;
    end

    a_r5_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop) |=> !core_clk_en);
    a_r5_clear_enables: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop) |=> core_clk_en);
endmodule

// File: rtl/dma_cfg_ctl.sv
// Module: top of the DMA configuration and freeze controller.
// Connects register storage, freeze gate and clock-enable register.
module dma_cfg_ctl
    import dma_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_super,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_ack,
    output logic              acc_berr,
    input  logic              freeze_in,
    input  logic              core_busy,
    input  logic              core_req,
    output logic              bus_req,
    output logic              core_clk_en
);
    logic       stop;
    logic [1:0] frz_mode;

    dma_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_super(acc_super), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_ack(acc_ack),
        .acc_berr(acc_berr), .stop(stop), .frz_mode(frz_mode)
    );

    dma_cfg_freeze u_frz (
        .clk(clk), .rst_n(rst_n), .frz_mode(frz_mode), .freeze_in(freeze_in),
        .core_busy(core_busy), .core_req(core_req), .bus_req(bus_req)
    );

    dma_cfg_clkgate u_cg (
        .clk(clk), .rst_n(rst_n), .stop(stop), .core_clk_en(core_clk_en)
    );
endmodule

// File: tb/dma_cfg_ctl_test.sv
// Bench: vector table of bus accesses, then directed stop and freeze tests.
module dma_cfg_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_super = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        acc_ack, acc_berr;
    logic        freeze_in = 1'b0, core_busy = 1'b0, core_req = 1'b1;
    logic        bus_req, core_clk_en;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    dma_cfg_ctl uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_super(acc_super), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_ack(acc_ack), .acc_berr(acc_berr),
        .freeze_in(freeze_in), .core_busy(core_busy), .core_req(core_req),
        .bus_req(bus_req), .core_clk_en(core_clk_en)
    );

    typedef struct packed {
        logic        wr;
        logic        sup;
        logic [11:0] addr;
        logic [15:0] wd;
        logic        ack;
        logic        berr;
        logic [15:0] rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 12'h780, 16'h0000, 1'b1, 1'b0, 16'h0080}, // R1
        '{1'b0, 1'b1, 12'h7A0, 16'h0000, 1'b1, 1'b0, 16'h0080}, // R1
        '{1'b1, 1'b1, 12'h780, 16'h5A3C, 1'b1, 1'b0, 16'h0000}, // R2
        '{1'b0, 1'b1, 12'h780, 16'h0000, 1'b1, 1'b0, 16'h523C}, // R2
        '{1'b0, 1'b1, 12'h7A0, 16'h0000, 1'b1, 1'b0, 16'h4080}, // R3
        '{1'b1, 1'b0, 12'h7A0, 16'hFFFF, 1'b0, 1'b1, 16'h0000}, // R4
        '{1'b0, 1'b1, 12'h7A0, 16'h0000, 1'b1, 1'b0, 16'h4080}, // R4
        '{1'b0, 1'b0, 12'h780, 16'h0000, 1'b0, 1'b1, 16'h0000}, // R4
        '{1'b1, 1'b1, 12'h7A0, 16'h2FFF, 1'b1, 1'b0, 16'h0000}, // R3
        '{1'b0, 1'b1, 12'h7A0, 16'h0000, 1'b1, 1'b0, 16'h27FF}, // R2
        '{1'b0, 1'b1, 12'h780, 16'h0000, 1'b1, 1'b0, 16'h323C}, // R3
        '{1'b0, 1'b1, 12'h790, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R6
        '{1'b1, 1'b1, 12'h780, 16'h123C, 1'b1, 1'b0, 16'h0000}, // R3
        '{1'b0, 1'b1, 12'h7A0, 16'h0000, 1'b1, 1'b0, 16'h07FF}  // R3
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: strobe after an edge, response sampled 2 ns after the next
    task automatic access(input logic w, input logic s, input logic [11:0] a,
                          input logic [15:0] d);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = w; acc_super = s;
        acc_addr = a; acc_wdata = d;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0;
        #1;
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state of the outputs
        check("R1 clk_en", 32'(core_clk_en), 32'd1);
        check("R1 bus_req", 32'(bus_req), 32'd1);
        check("R1 idle resp", {acc_ack, acc_berr}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].sup, VEC[i].addr, VEC[i].wd);
            check($sformatf("R2 vec%0d ack", i), 32'(acc_ack), 32'(VEC[i].ack));
            check($sformatf("R4 vec%0d berr", i), 32'(acc_berr), 32'(VEC[i].berr));
            check($sformatf("R3 vec%0d rdata", i), 32'(acc_rdata), 32'(VEC[i].rd));
        end

        // R5 stop drops the clock enable, register stays reachable
        access(1'b1, 1'b1, 12'h780, 16'h8000);
        tick();
        check("R5 clk_en low", 32'(core_clk_en), 32'd0);
        access(1'b0, 1'b1, 12'h7A0, 16'h0000);
        check("R5 read while stopped", {acc_ack, acc_rdata}, {16'd1, 16'h87FF});
        // R6 other window address faults while stopped
        access(1'b0, 1'b1, 12'h790, 16'h0000);
        check("R6 berr while stopped", {acc_ack, acc_berr}, 32'd1);
        access(1'b1, 1'b1, 12'h7A0, 16'h0000);
        tick();
        check("R5 clk_en back", 32'(core_clk_en), 32'd1);
        access(1'b0, 1'b1, 12'h790, 16'h0000);
        check("R6 no resp running", {acc_ack, acc_berr}, 32'd0);

        // R7 freeze at an idle boundary
        access(1'b1, 1'b1, 12'h780, 16'h4000);
        freeze_in = 1'b1;
        tick();
        check("R7 idle freeze", 32'(bus_req), 32'd0);
        freeze_in = 1'b0;
        tick();
        check("R9 release", 32'(bus_req), 32'd1);

        // R8 freeze during a bus cycle waits for its end
        core_busy = 1'b1;
        tick();
        freeze_in = 1'b1;
        repeat (3) tick();
        check("R8 mid-cycle", 32'(bus_req), 32'd1);
        core_busy = 1'b0;
        tick();
        check("R8 at boundary", 32'(bus_req), 32'd0);
        // R9 held through a new busy period until freeze drops
        core_busy = 1'b1;
        repeat (2) tick();
        check("R9 held busy", 32'(bus_req), 32'd0);
        core_busy = 1'b0;
        freeze_in = 1'b0;
        tick();
        check("R9 freeze negated", 32'(bus_req), 32'd1);

        // R10 reserved and ignore modes
        access(1'b1, 1'b1, 12'h7A0, 16'h6000);
        freeze_in = 1'b1;
        repeat (2) tick();
        check("R10 mode 11", 32'(bus_req), 32'd1);
        access(1'b1, 1'b1, 12'h7A0, 16'h2000);
        repeat (2) tick();
        check("R10 mode 01", 32'(bus_req), 32'd1);
        access(1'b1, 1'b1, 12'h7A0, 16'h0000);
        repeat (2) tick();
        check("R10 mode 00", 32'(bus_req), 32'd1);
        freeze_in = 1'b0;

        // R1 reset restores defaults after writes
        access(1'b1, 1'b1, 12'h780, 16'hF7FF);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        access(1'b0, 1'b1, 12'h780, 16'h0000);
        check("R1 reread after reset", 32'(acc_rdata), 32'h0080);
        check("R1 clk_en after reset", 32'(core_clk_en), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // watchdog: counts as a failed check and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule